// File: doc/BRIEF.md
# Two-Digit Binary/Decimal Character Converter

This block rewrites two adjacent character slots of a character-organised accumulator. It converts in either direction between a 6-bit binary value and a two-digit decimal number. Each character is seven bits wide. Six of them are data: bits 3:0 are the numeric nibble and bits 5:4 are the zone pair. Bit 6 is a parity bit. The block receives the low-order character, the high-order character, a direction select and a start strobe. One cycle later it returns both rewritten characters with fresh parity, together with a one-cycle done pulse.

In binary-to-decimal direction the six data bits of the low character are split into a tens digit and a units digit. The tens digit goes into the high character and the units digit into the low character, with both zone pairs cleared. In decimal-to-binary direction the two numeric nibbles are read as tens and units. The binary sum is placed in the low character and the high character's data bits are cleared. A sum above 63 raises a sticky overflow flag, which only a dedicated clear input lowers. The surrounding register file, the instruction decoder and the interrupt logic are outside this block.

Top module: `bcd_char_converter`

## Requirements
- R1: With `dir`=0 and `start`=1, the value v = `lo_in[5:0]` (0..63) produces, on the next cycle, `hi_out[3:0]` = v/10 and `lo_out[3:0]` = v mod 10.
- R2: In the `dir`=0 direction both `lo_out[5:4]` and `hi_out[5:4]` are 0 after the conversion.
- R3: With `dir`=1 and `start`=1, r = 10*`hi_in[3:0]` + `lo_in[3:0]`. On the next cycle `lo_out[5:0]` = r mod 64 and `hi_out[5:0]` = 0.
- R4: In the `dir`=1 direction a nibble above 9 is taken at its plain binary weight (10..15), so a nibble of 12 counts as 12 in the units position and as 120 in the tens position.
- R5: `ovf` goes to 1 on the cycle after a `dir`=1 conversion whose r exceeds 63. It stays 1 until cleared. A `dir`=0 conversion never raises it.
- R6: `ovf_clr`=1 makes `ovf` 0 on the next cycle, unless a `dir`=1 conversion with r > 63 is started in the same cycle. In that case the flag is set, because setting has priority over clearing.
- R7: Bit 6 of each output character is odd parity over its bits 5:0, so the seven bits together always hold an odd number of ones.
- R8: `done` is 1 exactly on the cycle after each cycle with `start`=1 and 0 otherwise. When `start` is 0 the output characters keep their values.
- R9: While `rst_n` is 0 at a clock edge, `lo_out` and `hi_out` become 7'h40 (data 0, parity 1), and `done` and `ovf` become 0.
- R10: The parity bits of both input characters, the zone bits of `hi_in`, and the whole of `hi_in` in the `dir`=0 direction have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Starts a conversion with the current inputs |
| dir | input | 1 | 0: binary to decimal, 1: decimal to binary |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| lo_in | input | 7 | Low-order character (parity at bit 6) |
| hi_in | input | 7 | High-order character (parity at bit 6) |
| lo_out | output | 7 | Rewritten low-order character |
| hi_out | output | 7 | Rewritten high-order character |
| done | output | 1 | One-cycle pulse marking a fresh result |
| ovf | output | 1 | Sticky decimal-to-binary overflow flag |

## Verification
The assertions take for granted that `dir`, `lo_in` and `hi_in` are valid, X-free values in every cycle where `start` is 1. They also assume that `start` and `ovf_clr` are never unknown once reset is released. The stimulus changes inputs only at the falling clock edge and holds them stable through the next rising edge. It keeps `start` low during reset. It fills every input bit, so the ignored parity and zone bits are driven to both values instead of being left floating.

// File: rtl/bcd_conv_pkg.sv
// Package: shared widths and the direction encoding for the character
// converter. Assumes one parity bit sits above the data bits of a character.
package bcd_conv_pkg;
    localparam int DATA_W = 6;           // data bits per character
    localparam int NUM_W  = 4;           // numeric nibble width
    localparam int CHAR_W = DATA_W + 1;  // data plus parity

    typedef enum logic {
        DIR_BIN2DEC = 1'b0,
        DIR_DEC2BIN = 1'b1
    } conv_dir_e;
endpackage

// File: rtl/bcd_bin2dec.sv
// Module: bcd_bin2dec
// Splits an unsigned binary value into a tens digit and a units digit by the
// shift-and-add-3 method. Purely combinational.
// Assumes the input is below 100, so two digits hold the result.
module bcd_bin2dec #(
    parameter int BIN_W = 6,
    parameter int DIG_W = 4
) (
    input  logic [BIN_W-1:0] bin,
    output logic [DIG_W-1:0] tens,
    output logic [DIG_W-1:0] units
);
    localparam int SCR_W = BIN_W + 2 * DIG_W;

    logic [SCR_W-1:0] scratch;

    // Walk the binary bits in from the top, correcting each digit before the shift.
    always_comb begin
        scratch = '0;
        scratch[BIN_W-1:0] = bin;
        for (int i = 0; i < BIN_W; i++) begin
            for (int d = 0; d < 2; d++) begin
                if (scratch[BIN_W + d*DIG_W +: DIG_W] >= DIG_W'(5))
                    scratch[BIN_W + d*DIG_W +: DIG_W] =
                        scratch[BIN_W + d*DIG_W +: DIG_W] + DIG_W'(3);
            end
            scratch = scratch << 1;
        end
    end

    // Hand out the two digit fields.
    always_comb begin
        units = scratch[BIN_W +: DIG_W];
        tens  = scratch[BIN_W + DIG_W +: DIG_W];
    end
endmodule

// File: rtl/bcd_dec2bin.sv
// Module: bcd_dec2bin
// Combines a tens nibble and a units nibble into 10*tens + units and flags
// sums that do not fit the output field. Nibbles above 9 keep their binary
// weight. Purely combinational.
module bcd_dec2bin #(
    parameter int DIG_W = 4,
    parameter int OUT_W = 6
) (
    input  logic [DIG_W-1:0] tens,
    input  logic [DIG_W-1:0] units,
    output logic [OUT_W-1:0] result,
    output logic             too_big
);
    localparam int SUM_W = DIG_W + 4;
    localparam int LIMIT = (1 << OUT_W) - 1;

    logic [SUM_W-1:0] sum;

    // Times ten as (x<<3)+(x<<1), then add the units digit.
    always_comb begin
        sum = (SUM_W'(tens) << 3) + (SUM_W'(tens) << 1) + SUM_W'(units);
    end

    // Truncate to the output field and judge the full sum against it.
    always_comb begin
        result  = sum[OUT_W-1:0];
        too_big = (sum > SUM_W'(LIMIT));
    end
endmodule

// File: rtl/bcd_parity.sv
// Module: bcd_parity
// Produces the odd-parity bit for one character's data bits.
module bcd_parity #(
    parameter int W = 6
) (
    input  logic [W-1:0] data,
    output logic         par
);
    // Parity is 1 when the data holds an even number of ones.
    always_comb par = ~(^data);
endmodule

// File: rtl/bcd_char_converter.sv
// Module: bcd_char_converter
// Converts two character slots in place between a 6-bit binary value and a
// two-digit decimal number. The result is registered one cycle after start,
// with done. Decimal-to-binary sums above 63 set a sticky flag.
// Assumes inputs are valid whenever start is high. Reset is synchronous and
// active low.
module bcd_char_converter
    import bcd_conv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir,
    input  logic              ovf_clr,
    input  logic [CHAR_W-1:0] lo_in,
    input  logic [CHAR_W-1:0] hi_in,
    output logic [CHAR_W-1:0] lo_out,
    output logic [CHAR_W-1:0] hi_out,
    output logic              done,
    output logic              ovf
);
    localparam int ZONE_W = DATA_W - NUM_W;

    conv_dir_e            dir_sel;
    logic [NUM_W-1:0]     b2d_tens;
    logic [NUM_W-1:0]     b2d_units;
    logic [DATA_W-1:0]    d2b_value;
    logic                 d2b_big;
    logic [DATA_W-1:0]    next_data [2];
    logic [1:0]           next_par;
    logic                 unused_in_bits;

    // Cast the raw select to the direction type.
    always_comb dir_sel = conv_dir_e'(dir);

    // Input bits this block reads in no mode.
    always_comb unused_in_bits = ^{lo_in[CHAR_W-1], hi_in[CHAR_W-1], hi_in[DATA_W-1:NUM_W]};

    bcd_bin2dec #(.BIN_W(DATA_W), .DIG_W(NUM_W)) u_b2d (
        .bin   (lo_in[DATA_W-1:0]),
        .tens  (b2d_tens),
        .units (b2d_units)
    );

    bcd_dec2bin #(.DIG_W(NUM_W), .OUT_W(DATA_W)) u_d2b (
        .tens    (hi_in[NUM_W-1:0]),
        .units   (lo_in[NUM_W-1:0]),
        .result  (d2b_value),
        .too_big (d2b_big)
    );

    // Pick the new data fields of the low (index 0) and high (index 1) slots.
    always_comb begin
        if (dir_sel == DIR_DEC2BIN) begin
            next_data[0] = d2b_value;
            next_data[1] = '0;
        end else begin
            next_data[0] = {{ZONE_W{1'b0}}, b2d_units};
            next_data[1] = {{ZONE_W{1'b0}}, b2d_tens};
        end
    end

    generate
        for (genvar c = 0; c < 2; c++) begin : g_par
            bcd_parity #(.W(DATA_W)) u_par (
                .data (next_data[c]),
                .par  (next_par[c])
            );
        end
    endgenerate

    // Capture the rewritten characters on start and hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_out <= {1'b1, {DATA_W{1'b0}}};
            hi_out <= {1'b1, {DATA_W{1'b0}}};
        end else if (start) begin
            lo_out <= {next_par[0], next_data[0]};
            hi_out <= {next_par[1], next_data[1]};
        end
    end

    // Pulse done for one cycle behind each start.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= start;
    end

    // Sticky overflow: a new overflow wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (start && dir_sel == DIR_DEC2BIN && d2b_big)
            ovf <= 1'b1;
        else if (ovf_clr)
            ovf <= 1'b0;
    end
endmodule

// File: rtl/bcd_conv_checker.sv
// Module: bcd_conv_checker
// Temporal checks on the converter's ports, attached to every instance by bind.
module bcd_conv_checker #(
    parameter int DATA_W = 6,
    parameter int NUM_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              dir,
    input logic              ovf_clr,
    input logic [DATA_W:0]   lo_out,
    input logic [DATA_W:0]   hi_out,
    input logic              done,
    input logic              ovf
);
    // R8
    done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    // R8
    done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));
    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(lo_out) && $stable(hi_out)));
    // R7
    lo_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (^lo_out) == 1'b1);
    // R7
    hi_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (^hi_out) == 1'b1);
    // R2
    zone_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dir) |=> (lo_out[DATA_W-1:NUM_W] == '0 && hi_out[DATA_W-1:NUM_W] == '0));
    // R3
    high_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dir) |=> (hi_out[DATA_W-1:0] == '0));
    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
    // R5
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(start && dir));
    // R6
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !(start && dir)) |=> !ovf);
endmodule

bind bcd_char_converter bcd_conv_checker #(
    .DATA_W (bcd_conv_pkg::DATA_W),
    .NUM_W  (bcd_conv_pkg::NUM_W)
) u_conv_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .dir     (dir),
    .ovf_clr (ovf_clr),
    .lo_out  (lo_out),
    .hi_out  (hi_out),
    .done    (done),
    .ovf     (ovf)
);

// File: tb/bcd_char_converter_test.sv
module bcd_char_converter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       dir = 1'b0;
    logic       ovf_clr = 1'b0;
    logic [6:0] lo_in = '0;
    logic [6:0] hi_in = '0;
    logic [6:0] lo_out;
    logic [6:0] hi_out;
    logic       done;
    logic       ovf;

    int checks = 0;
    int failures = 0;
    bit model_ovf = 1'b0;
    logic [6:0] last_lo = 7'h40;
    logic [6:0] last_hi = 7'h40;
    logic [14:0] sb_q[$];   // {ovf, hi, lo}
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bcd_char_converter uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .ovf_clr(ovf_clr),
        .lo_in(lo_in), .hi_in(hi_in), .lo_out(lo_out), .hi_out(hi_out),
        .done(done), .ovf(ovf)
    );

    function automatic logic [6:0] mk_char(input logic [5:0] d);
        int ones = 0;
        for (int i = 0; i < 6; i++) ones += d[i];
        return {(ones % 2 == 0) ? 1'b1 : 1'b0, d};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: compute the expectation, queue it, pulse start for one cycle.
    task automatic convert(input bit d, input logic [6:0] lo, input logic [6:0] hi, input bit clr);
        int v;
        logic [6:0] e_lo, e_hi;
        if (d) begin
            v = hi[3:0] * 10 + lo[3:0];           // R3 R4
            e_lo = mk_char(6'(v % 64));
            e_hi = mk_char(6'd0);
            if (v > 63) model_ovf = 1'b1;         // R5 R6
            else if (clr) model_ovf = 1'b0;
        end else begin
            v = lo[5:0];                           // R1 R2
            e_lo = mk_char({2'b00, 4'(v % 10)});
            e_hi = mk_char({2'b00, 4'(v / 10)});
            if (clr) model_ovf = 1'b0;
        end
        last_lo = e_lo;
        last_hi = e_hi;
        sb_q.push_back({model_ovf, e_hi, e_lo});
        @(negedge clk);
        start = 1'b1; dir = d; lo_in = lo; hi_in = hi; ovf_clr = clr;
        @(negedge clk);
        start = 1'b0; ovf_clr = 1'b0;
        lo_in = 7'($urandom); hi_in = 7'($urandom); dir = 1'($urandom);
    endtask

    // Idle cycles: no done pulse, outputs held (R8, R10 with scrambled inputs).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lo_in = 7'($urandom); hi_in = 7'($urandom);
            check("R8 idle done", done, 0);
            check("R8 hold lo", lo_out, last_lo);
            check("R8 hold hi", hi_out, last_hi);
        end
    endtask

    // Monitor: pop and compare each result as done appears.
    always @(negedge clk) begin
        logic [14:0] e;
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check("R8 unexpected done", 1, 0);
            end else begin
                e = sb_q.pop_front();
                check("R1 R3 R7 R10 lo_out", lo_out, e[6:0]);
                check("R1 R2 R3 R7 hi_out", hi_out, e[13:7]);
                check("R5 R6 ovf", ovf, e[14]);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9 reset state
        check("R9 lo_out", lo_out, 7'h40);
        check("R9 hi_out", hi_out, 7'h40);
        check("R9 done", done, 0);
        check("R9 ovf", ovf, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R10: every binary value, junk in parity, hi_in and zones
        for (int v = 0; v < 64; v++)
            convert(1'b0, {1'($urandom), 6'(v)}, 7'($urandom), 1'b0);
        check("R5 no ovf from dir=0", ovf, 0);
        idle(2);

        // R3 R4 R5 R10: every nibble pair, random zones and parity
        for (int t = 0; t < 16; t++)
            for (int u = 0; u < 16; u++) begin
                convert(1'b1, {3'($urandom), 4'(u)}, {3'($urandom), 4'(t)}, 1'b0);
                if (u == 15) idle(1);
            end

        // R6 clear alone
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0; model_ovf = 1'b0;
        check("R6 clear", ovf, 0);

        // R5 boundary 63 vs 64
        convert(1'b1, 7'h03, 7'h06, 1'b0);   // 63
        idle(1);
        check("R5 63 no ovf", ovf, 0);
        convert(1'b1, 7'h04, 7'h06, 1'b0);   // 64
        idle(1);
        check("R5 64 sets", ovf, 1);
        idle(3);
        check("R5 sticky", ovf, 1);

        // R6 set wins over clear; then clear with a fitting conversion
        convert(1'b1, 7'h09, 7'h09, 1'b1);   // 99 + clear
        check("R6 set priority", ovf, 1);
        convert(1'b1, 7'h02, 7'h01, 1'b1);   // 12 + clear
        check("R6 clear with fit", ovf, 0);
        convert(1'b0, 7'h3F, 7'h00, 1'b1);   // dir=0 + clear, R4 style junk
        idle(2);

        // Back-to-back starts (R8)
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            logic [6:0] e_lo, e_hi;
            e_lo = mk_char({2'b00, 4'((k * 17) % 10)});
            e_hi = mk_char({2'b00, 4'((k * 17) / 10)});
            sb_q.push_back({model_ovf, e_hi, e_lo});
            last_lo = e_lo; last_hi = e_hi;
            start = 1'b1; dir = 1'b0; lo_in = {1'b0, 6'(k * 17)};
            @(negedge clk);
        end
        start = 1'b0;
        idle(2);

        check("scoreboard drained", sb_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule